// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Shared Debug Pins

This block is a boundary-scan test access port controller whose reset and mode-select inputs share their pins with a serial debug interface. A three-bit test-mode input decides how the two shared pins are used. In one mode they are the TAP's reset and mode-select. In another they are passed out as the debug serial clock and breakpoint request. In every other mode the TAP is held in reset.

The controller contains the standard 16-state TAP state machine, which is clocked by the test clock. It also contains a 4-bit instruction register, a 32-bit identification register and a one-bit bypass register. The serial output is retimed to the falling edge of the test clock and comes with its own output enable. A board or a tester drives the pins. The surrounding chip reads the two debug outputs. The block keeps all of its state in flops, so the test clock may be stopped at either level for any length of time.

Top module: `jtag_shared_tap`

## Requirements
- R1: The TAP state machine follows the 16-state boundary-scan transition graph on each rising test-clock edge, based on the mode-select input. Serial data input is sampled on rising edges.
- R2: A low level on the reset pin in mode 000 forces the Test-Logic-Reset state at once, without waiting for a clock edge, and drops the output enable. Afterwards the identification instruction is selected.
- R3: Five rising edges with mode-select high reach Test-Logic-Reset from any state. This also selects the identification instruction.
- R4: The output enable is high only in the Shift-IR and Shift-DR states. The serial output changes only on falling test-clock edges.
- R5: Capture-IR loads 0001 into the instruction shift register. The shift register shifts LSB first, with serial input entering at the MSB. The new instruction takes effect on the falling edge in Update-IR.
- R6: Instruction code 0010 selects a 32-bit identification register. It captures 0x4F1CA02B (LSB is 1) in Capture-DR and shifts it out LSB first.
- R7: Code 1111 and every code other than 0010 select a one-bit bypass register. It captures 0 in Capture-DR and then passes serial input to the output delayed by one shift.
- R8: In mode 000 the shared pins go to the TAP, and both debug outputs are held at 0.
- R9: In mode 001 the debug clock output follows the reset pin and the breakpoint output follows the mode-select pin. The TAP meanwhile sees mode-select high and reset negated.
- R10: For any mode other than 000 and 001, the TAP's internal reset is held active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| tms_bkpt_i | input | 1 | Shared pin: TAP mode-select or debug breakpoint |
| trst_dsclk_i | input | 1 | Shared pin: active-low TAP reset or debug serial clock |
| tdi_i | input | 1 | Serial test data input |
| test_mode_i | input | 3 | Pin-function select |
| tdo_o | output | 1 | Serial test data output |
| tdo_oe_o | output | 1 | Output enable for tdo_o |
| dsclk_o | output | 1 | Debug serial clock to the debug side |
| bkpt_o | output | 1 | Breakpoint request to the debug side |

## Verification
The debug outputs and the TAP reset follow the pins combinationally, so they are checked 1 ns after the pin or mode changes. Each shift happens on a rising edge, but the matching bit appears on tdo_o and tdo_oe_o only at the next falling edge, half a cycle later. All serial reads are therefore taken 1 ns after that falling edge. One directed check also samples just after the rising edge to confirm that the output has not moved yet. A new instruction takes effect at the falling edge in Update-IR. The bench confirms this by a data scan through Capture-DR afterwards.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_e;
endpackage

// File: rtl/tap_pin_mux.sv
module tap_pin_mux #(
  parameter logic [2:0] TAP_MODE = 3'b000,
  parameter logic [2:0] DBG_MODE = 3'b001
) (
  input  logic [2:0] mode_i,
  input  logic       pin_rst_clk_i,
  input  logic       pin_sel_brk_i,
  output logic       trst_n_o,
  output logic       tms_o,
  output logic       dsclk_o,
  output logic       bkpt_o
);
  always_comb begin
    trst_n_o = 1'b0;   // unused modes: reset held active
    tms_o    = 1'b1;
    dsclk_o  = 1'b0;
    bkpt_o   = 1'b0;
    if (mode_i == TAP_MODE) begin
      trst_n_o = pin_rst_clk_i;
      tms_o    = pin_sel_brk_i;
    end else if (mode_i == DBG_MODE) begin
      trst_n_o = 1'b1;
      dsclk_o  = pin_rst_clk_i;
      bkpt_o   = pin_sel_brk_i;
    end
  end
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm import jtag_tap_pkg::*; (
  input  logic       tck_i,
  input  logic       trst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      ST_TLR:      state_d = tms_i ? ST_TLR      : ST_RTI;
      ST_RTI:      state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      ST_SEL_DR:   state_d = tms_i ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: state_d = tms_i ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_d = tms_i ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: state_d = tms_i ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      ST_SEL_IR:   state_d = tms_i ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: state_d = tms_i ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_d = tms_i ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: state_d = tms_i ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_d = tms_i ? ST_SEL_DR   : ST_RTI;
      default:     state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge trst_ni) begin
    if (!trst_ni) state_q <= ST_TLR;
    else          state_q <= state_d;
  end

  assign state_o = state_q;

  assert_tlr_exit_R1: assert property (@(posedge tck_i) disable iff (!trst_ni)
    (state_q == ST_TLR && !tms_i) |=> state_q == ST_RTI);

  assert_five_ones_R3: assert property (@(posedge tck_i) disable iff (!trst_ni)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
    |=> state_q == ST_TLR);
endmodule

// File: rtl/tap_ir.sv
module tap_ir import jtag_tap_pkg::*; #(
  parameter int unsigned      IR_W      = 4,
  parameter logic [IR_W-1:0]  IDCODE_OP = 4'h2
) (
  input  logic            tck_i,
  input  logic            trst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic            shift_lsb_o,
  output logic [IR_W-1:0] instr_o
);
  localparam logic [IR_W-1:0] CAPTURE_PAT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] shift_q;
  logic [IR_W-1:0] instr_q;

  always_ff @(posedge tck_i or negedge trst_ni) begin
    if (!trst_ni)                    shift_q <= CAPTURE_PAT;
    else if (state_i == ST_CAP_IR)   shift_q <= CAPTURE_PAT;
    else if (state_i == ST_SHIFT_IR) shift_q <= {tdi_i, shift_q[IR_W-1:1]};
  end

  always_ff @(negedge tck_i or negedge trst_ni) begin
    if (!trst_ni)                  instr_q <= IDCODE_OP;
    else if (state_i == ST_TLR)    instr_q <= IDCODE_OP;
    else if (state_i == ST_UPD_IR) instr_q <= shift_q;
  end

  assign shift_lsb_o = shift_q[0];
  assign instr_o     = instr_q;

  assert_capture_pat_R5: assert property (@(posedge tck_i) disable iff (!trst_ni)
    state_i == ST_CAP_IR |=> shift_q == CAPTURE_PAT);

  assert_tlr_idcode_R3: assert property (@(negedge tck_i) disable iff (!trst_ni)
    state_i == ST_TLR |=> instr_q == IDCODE_OP);
endmodule

// File: rtl/tap_dr.sv
module tap_dr import jtag_tap_pkg::*; #(
  parameter int unsigned      IR_W      = 4,
  parameter int unsigned      ID_W      = 32,
  parameter logic [IR_W-1:0]  IDCODE_OP = 4'h2,
  parameter logic [ID_W-1:0]  ID_VALUE  = 32'h4F1C_A02B
) (
  input  logic            tck_i,
  input  logic            trst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  input  logic [IR_W-1:0] instr_i,
  output logic            dr_lsb_o
);
  logic            sel_id;
  logic [ID_W-1:0] id_q;
  logic            byp_q;

  // only one defined data instruction; every other code is bypass
  assign sel_id = (instr_i == IDCODE_OP);

  always_ff @(posedge tck_i or negedge trst_ni) begin
    if (!trst_ni) begin
      id_q  <= ID_VALUE;
      byp_q <= 1'b0;
    end else if (state_i == ST_CAP_DR) begin
      id_q  <= ID_VALUE;
      byp_q <= 1'b0;
    end else if (state_i == ST_SHIFT_DR) begin
      if (sel_id) id_q  <= {tdi_i, id_q[ID_W-1:1]};
      else        byp_q <= tdi_i;
    end
  end

  assign dr_lsb_o = sel_id ? id_q[0] : byp_q;

  assert_bypass_capture_R7: assert property (@(posedge tck_i) disable iff (!trst_ni)
    state_i == ST_CAP_DR |=> !byp_q);

  assert_id_capture_R6: assert property (@(posedge tck_i) disable iff (!trst_ni)
    state_i == ST_CAP_DR |=> id_q == ID_VALUE);
endmodule

// File: rtl/jtag_shared_tap.sv
module jtag_shared_tap import jtag_tap_pkg::*; #(
  parameter int unsigned      IR_W      = 4,
  parameter int unsigned      ID_W      = 32,
  parameter logic [IR_W-1:0]  IDCODE_OP = 4'h2,
  parameter logic [ID_W-1:0]  ID_VALUE  = 32'h4F1C_A02B
) (
  input  logic       tck_i,
  input  logic       tms_bkpt_i,
  input  logic       trst_dsclk_i,
  input  logic       tdi_i,
  input  logic [2:0] test_mode_i,
  output logic       tdo_o,
  output logic       tdo_oe_o,
  output logic       dsclk_o,
  output logic       bkpt_o
);
  logic            trst_n;
  logic            tms;
  tap_state_e      state;
  logic            ir_lsb;
  logic            dr_lsb;
  logic [IR_W-1:0] instr;
  logic            shift_ir, shift_dr;
  logic            tdo_q, oe_q;

  tap_pin_mux u_mux (
    .mode_i        (test_mode_i),
    .pin_rst_clk_i (trst_dsclk_i),
    .pin_sel_brk_i (tms_bkpt_i),
    .trst_n_o      (trst_n),
    .tms_o         (tms),
    .dsclk_o       (dsclk_o),
    .bkpt_o        (bkpt_o)
  );

  tap_fsm u_fsm (
    .tck_i   (tck_i),
    .trst_ni (trst_n),
    .tms_i   (tms),
    .state_o (state)
  );

  tap_ir #(.IR_W(IR_W), .IDCODE_OP(IDCODE_OP)) u_ir (
    .tck_i       (tck_i),
    .trst_ni     (trst_n),
    .tdi_i       (tdi_i),
    .state_i     (state),
    .shift_lsb_o (ir_lsb),
    .instr_o     (instr)
  );

  tap_dr #(.IR_W(IR_W), .ID_W(ID_W), .IDCODE_OP(IDCODE_OP), .ID_VALUE(ID_VALUE)) u_dr (
    .tck_i    (tck_i),
    .trst_ni  (trst_n),
    .tdi_i    (tdi_i),
    .state_i  (state),
    .instr_i  (instr),
    .dr_lsb_o (dr_lsb)
  );

  assign shift_ir = (state == ST_SHIFT_IR);
  assign shift_dr = (state == ST_SHIFT_DR);

  // output retimed to the falling edge
  always_ff @(negedge tck_i or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= shift_ir | shift_dr;
      if (shift_ir)      tdo_q <= ir_lsb;
      else if (shift_dr) tdo_q <= dr_lsb;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

  assert_oe_shift_only_R4: assert property (@(posedge tck_i) disable iff (!trst_n)
    tdo_oe_o |-> (state == ST_SHIFT_IR || state == ST_SHIFT_DR));

  assert_unused_mode_reset_R10: assert property (@(posedge tck_i)
    (test_mode_i != 3'b000 && test_mode_i != 3'b001) |-> (state == ST_TLR && !tdo_oe_o));
endmodule

// File: tb/jtag_shared_tap_test.sv
`timescale 1ns/1ps
module jtag_shared_tap_test;
  localparam logic [31:0] EXP_ID  = 32'h4F1C_A02B;
  localparam logic [31:0] EXP_BYP = 32'hFFFF_FFFE; // captured 0, then ones from tdi

  // {instruction code, expected 32-bit read with tdi held at 1}
  localparam logic [35:0] VEC [6] = '{
    {4'hF, EXP_BYP}, {4'h2, EXP_ID}, {4'h0, EXP_BYP},
    {4'h7, EXP_BYP}, {4'h1, EXP_BYP}, {4'hE, EXP_BYP}
  };

  logic       tck = 1'b0;
  logic       tms_pin, trst_pin, tdi;
  logic [2:0] mode;
  logic       tdo, oe, dsclk, bkpt;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 0;

  always #2.5 tck = ~tck;

  jtag_shared_tap uut (
    .tck_i(tck), .tms_bkpt_i(tms_pin), .trst_dsclk_i(trst_pin), .tdi_i(tdi),
    .test_mode_i(mode), .tdo_o(tdo), .tdo_oe_o(oe), .dsclk_o(dsclk), .bkpt_o(bkpt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one full cycle; returns 1 ns after the falling edge
  task automatic step(input logic t, input logic d);
    tms_pin = t;
    tdi     = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic five_ones();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
  endtask

  // from Run-Test/Idle, back to Run-Test/Idle
  task automatic load_ir(input logic [3:0] code, output logic [3:0] capt);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    capt[0] = tdo;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      if (i < 3) capt[i+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(output logic [31:0] word, output logic oe_in, output logic oe_out);
    step(1, 0); step(0, 0); step(0, 0);
    word[0] = tdo;
    oe_in   = oe;
    for (int i = 0; i < 32; i++) begin
      step(i == 31, 1'b1);
      if (i < 31) word[i+1] = tdo;
    end
    oe_out = oe;
    step(1, 0); step(0, 0);
  endtask

  initial begin
    logic [3:0]  capt;
    logic [31:0] word;
    logic        oe_in, oe_out, v0;
    mode = 3'b000; trst_pin = 1'b0; tms_pin = 1'b1; tdi = 1'b0;
    #12;
    // reset state; R8 debug outputs held in mode 000
    check("R2 oe in reset", oe, 0);
    check("R8 dsclk_o in mode 000", dsclk, 0);
    trst_pin = 1'b1;
    #1;
    check("R8 dsclk_o stays 0", dsclk, 0);
    @(negedge tck); #1;
    step(0, 0);
    scan_dr(word, oe_in, oe_out);
    check("R2 IDCODE after reset", word, EXP_ID);
    check("R4 oe in Shift-DR", oe_in, 1);
    check("R4 oe after Exit1-DR", oe_out, 0);
    check("R4 oe in Run-Test/Idle", oe, 0);

    // vector table: R1 R5 R6 R7
    foreach (VEC[k]) begin
      five_ones();
      step(0, 0);
      load_ir(VEC[k][35:32], capt);
      check($sformatf("R5 capture-IR code %h", VEC[k][35:32]), capt, 4'b0001);
      scan_dr(word, oe_in, oe_out);
      check($sformatf("R1 R6 R7 DR scan code %h", VEC[k][35:32]), word, VEC[k][31:0]);
    end
    check("R8 bkpt_o in mode 000", bkpt, 0);

    // R4: output moves only on the falling edge
    five_ones(); step(0, 0);
    step(1, 0); step(0, 0); step(0, 0);
    check("R4 first ID bit", tdo, EXP_ID[0]);
    tms_pin = 0; tdi = 1;
    @(posedge tck); #1;
    check("R4 tdo held after rising edge", tdo, EXP_ID[0]);
    @(negedge tck); #1;
    check("R4 tdo after falling edge", tdo, EXP_ID[1]);

    // R3: five ones from inside Shift-DR
    five_ones();
    check("R3 oe after five ones", oe, 0);
    step(0, 0);
    load_ir(4'hF, capt);
    step(1, 0); step(0, 0); step(0, 0);
    five_ones(); step(0, 0);
    scan_dr(word, oe_in, oe_out);
    check("R3 IDCODE after TMS reset", word, EXP_ID);

    // R2: asynchronous reset mid-shift
    load_ir(4'hF, capt);
    step(1, 0); step(0, 0); step(0, 0);
    check("R2 oe before reset", oe, 1);
    tms_pin = 1; #0.5; trst_pin = 0; #0.5;
    check("R2 oe drops without clock", oe, 0);
    trst_pin = 1;
    @(negedge tck); #1;
    step(0, 0);
    scan_dr(word, oe_in, oe_out);
    check("R2 IDCODE after async reset", word, EXP_ID);

    // R10: unused modes hold the TAP in reset
    for (int m = 2; m < 8; m++) begin
      load_ir(4'hF, capt);
      step(1, 0); step(0, 0); step(0, 0);
      mode = 3'(m); #0.5;
      check($sformatf("R10 oe mode %0d", m), oe, 0);
      check($sformatf("R10 dsclk_o mode %0d", m), dsclk, 0);
      step(0, 1);
      mode = 3'b000;
      step(0, 0);
      scan_dr(word, oe_in, oe_out);
      check($sformatf("R10 IDCODE after mode %0d", m), word, EXP_ID);
    end

    // R9: debug mode pass-through
    load_ir(4'hF, capt);
    mode = 3'b001;
    trst_pin = 0; #0.5;
    check("R9 dsclk_o low", dsclk, 0);
    trst_pin = 1; #0.5;
    check("R9 dsclk_o high", dsclk, 1);
    tms_pin = 0; #0.5;
    check("R9 bkpt_o low", bkpt, 0);
    tms_pin = 1; #0.5;
    check("R9 bkpt_o high", bkpt, 1);
    @(negedge tck); #1;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0); // pin tms low, TAP sees high
    mode = 3'b000;
    step(0, 0);
    scan_dr(word, oe_in, oe_out);
    check("R9 TAP driven to reset in debug mode", word, EXP_ID);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule